// File: doc/BRIEF.md
# Refresh Interval Scheduler with Postponement

This block tells a DRAM controller when an auto-refresh command is due. A free-running interval timer grants one refresh credit every `INTERVAL_CYC` clock cycles, which is the average refresh period expressed in cycles. The controller may let credits pile up while it serves traffic, up to `MAX_DEBT` owed refreshes. Each refresh command it issues is reported back on an acknowledge strobe, which pays off one credit. Each refresh needs its own command, and the device generates the row address itself, so the scheduler drives no address.

Two outputs drive the controller. The request output means at least one refresh is owed. The urgent output means the controller must refresh now. Urgency is raised in two cases. The first is when the debt has reached its limit. The second is when the time since the last acknowledged refresh comes within `URGENT_MARGIN` cycles of `(MAX_DEBT+1) * INTERVAL_CYC`, the longest permitted gap between two refresh commands. The device also relies on refresh for its output-driver and termination recalibration, so that gap must never be exceeded.

A refresh may be pulled in ahead of time. An acknowledge that arrives with no credit owed puts the scheduler one credit ahead. The next interval grant is then absorbed, and no further early refresh is counted.

Top module: `refresh_sched`

## Requirements
- R1: While `rst_n` is low at a clock edge, both `ref_req` and `ref_urgent` are 0 after that edge, and the credit level, interval timer and gap timer restart from zero.
- R2: After reset is released, `ref_req` stays 0 for the first `INTERVAL_CYC - 1` clock edges and becomes 1 at edge `INTERVAL_CYC`.
- R3: A `ref_ack` sampled while one or more credits are owed, and with no interval grant in that cycle, lowers the owed count by one. `ref_req` falls when the count reaches zero.
- R4: The owed count saturates at `MAX_DEBT`. `ref_urgent` rises in the cycle the count reaches `MAX_DEBT`. After further grants at saturation, exactly `MAX_DEBT` acknowledges clear `ref_req`.
- R5: A `ref_ack` sampled with zero credits owed moves the scheduler one credit ahead, so the next interval grant leaves `ref_req` at 0. A second such acknowledge while already one ahead has no effect.
- R6: When an interval grant and a `ref_ack` fall on the same clock edge, the credit level is unchanged.
- R7: `ref_urgent` is 1 whenever the number of edges since the last acknowledged refresh (or since reset) is at least `(MAX_DEBT+1)*INTERVAL_CYC - URGENT_MARGIN`, even when the owed count is below `MAX_DEBT`. An acknowledge clears that gap count to zero.
- R8: `ref_req` is 1 whenever `ref_urgent` is 1.
- R9: Interval grants keep a fixed period of `INTERVAL_CYC` edges measured from reset, whatever acknowledges arrive.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| ref_ack | input | 1 | One-cycle strobe: a refresh command was issued this cycle |
| ref_req | output | 1 | At least one refresh is owed, or one is urgent |
| ref_urgent | output | 1 | A refresh must be issued now (debt at limit or gap near expiry) |

## Verification
Two functions can fall in the same cycle. The interval timer's credit grant and the controller's acknowledge can land on the same edge, and their net effect must leave the level untouched. The bench provokes this by holding `ref_ack` high across the edge where a grant is due (edge 32 with a 16-cycle interval). It then judges the result by checking that exactly one further acknowledge drops `ref_req`. The gap-timer urgency is separated from debt urgency by first pulling a refresh in. The bench then confirms that `ref_urgent` rises a few cycles before the debt could reach its limit.

// File: rtl/refresh_sched_pkg.sv
// Package: refresh_sched_pkg
// Shared types for the refresh scheduler. Assumes nothing beyond
// IEEE 1800-2017 packages; holds only the credit action encoding.
package refresh_sched_pkg;

    // What the credit counter does on the next edge.
    typedef enum logic [1:0] {
        CR_HOLD = 2'd0,
        CR_INC  = 2'd1,
        CR_DEC  = 2'd2
    } credit_act_t;

endpackage

// File: rtl/refresh_interval_timer.sv
// Module: refresh_interval_timer
// Free-running cycle counter that emits a one-cycle grant strobe every
// INTERVAL_CYC cycles. The first grant comes at the INTERVAL_CYC-th edge
// after reset. Assumes INTERVAL_CYC >= 2.
module refresh_interval_timer #(
    parameter int INTERVAL_CYC = 1560
) (
    input  logic clk,
    input  logic rst_n,
    output logic grant
);
    localparam int CW = (INTERVAL_CYC > 2) ? $clog2(INTERVAL_CYC) : 1;
    localparam logic [CW-1:0] LAST = CW'(INTERVAL_CYC - 1);

    logic [CW-1:0] cyc_q;

    // Grant on the last count of each interval.
    assign grant = (cyc_q == LAST);

    // Advance the counter, wrapping at the end of each interval.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cyc_q <= '0;
        else if (grant)
            cyc_q <= '0;
        else
            cyc_q <= cyc_q + 1'b1;
    end

    // R9: after a grant the counter restarts, so grants are INTERVAL_CYC apart.
    p_grant_restart_r9: assert property (@(posedge clk) disable iff (!rst_n)
        grant |=> (cyc_q == '0));

    // R9: the counter never passes the last count.
    p_count_bound_r9: assert property (@(posedge clk) disable iff (!rst_n)
        cyc_q <= LAST);

endmodule

// File: rtl/refresh_credit_counter.sv
// Module: refresh_credit_counter
// Tracks the refresh balance as an offset level. Level 0 means one refresh
// has been pulled in, level 1 means nothing is owed, and level MAX_DEBT+1
// means the debt is at its limit. Assumes grant and ack are one-cycle strobes.
module refresh_credit_counter
    import refresh_sched_pkg::*;
#(
    parameter int MAX_DEBT = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic grant,
    input  logic ack,
    output logic owed,
    output logic at_limit
);
    localparam int LW = $clog2(MAX_DEBT + 2);
    localparam logic [LW-1:0] LV_AHEAD = '0;
    localparam logic [LW-1:0] LV_EVEN  = LW'(1);
    localparam logic [LW-1:0] LV_TOP   = LW'(MAX_DEBT + 1);

    logic [LW-1:0] lvl_q;
    credit_act_t   act;

    // Choose the action: a grant and an ack together cancel; limits clamp.
    always_comb begin
        act = CR_HOLD;
        if (grant && !ack && lvl_q != LV_TOP)
            act = CR_INC;
        else if (ack && !grant && lvl_q != LV_AHEAD)
            act = CR_DEC;
    end

    // Apply the chosen action to the level register.
    always_ff @(posedge clk) begin
        if (!rst_n)
            lvl_q <= LV_EVEN;
        else begin
            case (act)
                CR_INC:  lvl_q <= lvl_q + 1'b1;
                CR_DEC:  lvl_q <= lvl_q - 1'b1;
                default: lvl_q <= lvl_q;
            endcase
        end
    end

    // Decode the outputs from the level.
    assign owed     = (lvl_q > LV_EVEN);
    assign at_limit = (lvl_q == LV_TOP);

    // R4: the level never leaves its legal range.
    p_level_range_r4: assert property (@(posedge clk) disable iff (!rst_n)
        lvl_q <= LV_TOP);

    // R6: a grant and an ack on the same edge leave the level unchanged.
    p_cancel_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (grant && ack) |=> $stable(lvl_q));

    // R3: an ack alone with debt owed lowers the level by exactly one.
    p_ack_pays_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (ack && !grant && lvl_q > LV_EVEN) |=> (lvl_q == $past(lvl_q) - 1'b1));

    // R5: no more than one refresh may be pulled in.
    p_pullin_limit_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (ack && !grant && lvl_q == LV_AHEAD) |=> (lvl_q == LV_AHEAD));

    // R4: a grant at the limit does not wrap the level.
    p_saturate_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (grant && !ack && lvl_q == LV_TOP) |=> (lvl_q == LV_TOP));

endmodule

// File: rtl/refresh_gap_timer.sv
// Module: refresh_gap_timer
// Counts cycles since the last acknowledged refresh, saturating at the
// longest allowed gap. Flags when the count is within URGENT_MARGIN of
// that gap. Assumes URGENT_MARGIN is below GAP_LIMIT.
module refresh_gap_timer #(
    parameter int GAP_LIMIT     = 14040,
    parameter int URGENT_MARGIN = 64
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ack,
    output logic near_expiry
);
    localparam int GW = $clog2(GAP_LIMIT + 1);
    localparam logic [GW-1:0] GAP_MAX  = GW'(GAP_LIMIT);
    localparam logic [GW-1:0] GAP_WARN = GW'(GAP_LIMIT - URGENT_MARGIN);

    logic [GW-1:0] gap_q;

    // Restart on each acknowledged refresh, else count up to the limit.
    always_ff @(posedge clk) begin
        if (!rst_n)
            gap_q <= '0;
        else if (ack)
            gap_q <= '0;
        else if (gap_q != GAP_MAX)
            gap_q <= gap_q + 1'b1;
    end

    // Warn once the gap comes within the margin of its limit.
    assign near_expiry = (gap_q >= GAP_WARN);

    // R7: an acknowledged refresh restarts the gap count.
    p_gap_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ack |=> (gap_q == '0));

    // R7: the gap count never passes the limit.
    p_gap_bound_r7: assert property (@(posedge clk) disable iff (!rst_n)
        gap_q <= GAP_MAX);

endmodule

// File: rtl/refresh_sched.sv
// Module: refresh_sched
// Top of the refresh scheduler. It grants refresh credits at the average
// interval, lets the controller postpone up to MAX_DEBT of them, and raises
// urgency at the debt limit or before the longest refresh-to-refresh gap
// ((MAX_DEBT+1) intervals) runs out. Assumes ref_ack pulses once per issued
// refresh command.
module refresh_sched #(
    parameter int INTERVAL_CYC  = 1560,
    parameter int MAX_DEBT      = 8,
    parameter int URGENT_MARGIN = 64
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ref_ack,
    output logic ref_req,
    output logic ref_urgent
);
    localparam int GAP_LIMIT = (MAX_DEBT + 1) * INTERVAL_CYC;

    logic grant;
    logic owed;
    logic at_limit;
    logic near_expiry;

    // Interval grant generator.
    refresh_interval_timer #(
        .INTERVAL_CYC (INTERVAL_CYC)
    ) u_interval (
        .clk   (clk),
        .rst_n (rst_n),
        .grant (grant)
    );

    // Postponement balance.
    refresh_credit_counter #(
        .MAX_DEBT (MAX_DEBT)
    ) u_credit (
        .clk      (clk),
        .rst_n    (rst_n),
        .grant    (grant),
        .ack      (ref_ack),
        .owed     (owed),
        .at_limit (at_limit)
    );

    // Absolute gap watchdog.
    refresh_gap_timer #(
        .GAP_LIMIT     (GAP_LIMIT),
        .URGENT_MARGIN (URGENT_MARGIN)
    ) u_gap (
        .clk         (clk),
        .rst_n       (rst_n),
        .ack         (ref_ack),
        .near_expiry (near_expiry)
    );

    // Combine the balance and the watchdog into the two outputs.
    assign ref_urgent = at_limit | near_expiry;
    assign ref_req    = owed | ref_urgent;

    // R8: urgency always comes with a request.
    p_urgent_has_req_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ref_urgent |-> ref_req);

    // R1: the cycle after a reset edge, both outputs are quiet.
    p_reset_quiet_r1: assert property (@(posedge clk)
        !rst_n |=> (!ref_req && !ref_urgent));

endmodule

// File: tb/refresh_sched_test.sv
// Directed bench for refresh_sched: 16-cycle interval, debt limit 8,
// urgency margin 4, so the longest gap is 144 cycles and the gap warning
// fires at 140. Inputs change and outputs are sampled on falling edges.
module refresh_sched_test;
    localparam int CLK_PERIOD = 10;
    localparam int IV   = 16;
    localparam int DEBT = 8;
    localparam int MARG = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ref_ack = 1'b0;
    logic ref_req;
    logic ref_urgent;

    int nvec = 0;
    int nfail = 0;

    refresh_sched #(
        .INTERVAL_CYC  (IV),
        .MAX_DEBT      (DEBT),
        .URGENT_MARGIN (MARG)
    ) uut (
        .clk        (clk),
        .rst_n      (rst_n),
        .ref_ack    (ref_ack),
        .ref_req    (ref_req),
        .ref_urgent (ref_urgent)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    task automatic check(input logic got, input logic exp, input string tag);
        nvec++;
        if (got !== exp) begin
            nfail++;
            $display("FAIL %s: got %b expected %b", tag, got, exp);
        end
    endtask

    task automatic advance(input int k);
        repeat (k) @(negedge clk);
    endtask

    task automatic pulse_ack();
        ref_ack = 1'b1;
        @(negedge clk);
        ref_ack = 1'b0;
    endtask

    // Reset and check quiet outputs; returns at edge count n = 0.
    task automatic t_reset();
        @(negedge clk);
        rst_n = 1'b0;
        ref_ack = 1'b0;
        advance(2);
        check(ref_req, 1'b0, "R1 req in reset");
        check(ref_urgent, 1'b0, "R1 urgent in reset");
        rst_n = 1'b1;
    endtask

    // First grant timing, ack drain, and free-running spacing.
    task automatic t_first_credit();
        t_reset();
        advance(IV - 1);
        check(ref_req, 1'b0, "R2 req before first interval");
        advance(1);
        check(ref_req, 1'b1, "R2 req at first interval");
        pulse_ack();
        check(ref_req, 1'b0, "R3 req after paying the only credit");
        advance(IV - 2);
        check(ref_req, 1'b0, "R9 req one edge before second grant");
        advance(1);
        check(ref_req, 1'b1, "R9 req at second grant despite ack");
    endtask

    // Debt climbs to the limit, saturates, and drains with exactly DEBT acks.
    task automatic t_saturate();
        t_reset();
        advance(DEBT * IV - 1);
        check(ref_urgent, 1'b0, "R4 urgent one edge before debt limit");
        advance(1);
        check(ref_urgent, 1'b1, "R4 urgent at debt limit");
        check(ref_req, 1'b1, "R8 req with urgent at debt limit");
        advance(IV);
        check(ref_urgent, 1'b1, "R4 urgent after grant at limit");
        pulse_ack();
        check(ref_urgent, 1'b0, "R7 urgent cleared by ack below limit");
        for (int i = 0; i < DEBT - 2; i++) pulse_ack();
        check(ref_req, 1'b1, "R4 req with one credit left");
        pulse_ack();
        check(ref_req, 1'b0, "R4 req clear after exactly DEBT acks");
    endtask

    // Pull-in: one early refresh absorbs the next grant; a second is ignored.
    task automatic t_pullin();
        t_reset();
        advance(IV);
        pulse_ack();
        pulse_ack();
        check(ref_req, 1'b0, "R5 req after pull-in");
        pulse_ack();
        advance(IV - 3);
        check(ref_req, 1'b0, "R5 grant absorbed by pulled-in refresh");
        advance(IV);
        check(ref_req, 1'b1, "R5 second pull-in had no effect");
    endtask

    // Grant and ack on the same edge leave the level unchanged.
    task automatic t_coincident();
        t_reset();
        advance(2 * IV - 1);
        ref_ack = 1'b1;
        advance(1);
        ref_ack = 1'b0;
        check(ref_req, 1'b1, "R6 req after coincident grant and ack");
        pulse_ack();
        check(ref_req, 1'b0, "R6 one ack clears the single credit");
    endtask

    // Gap urgency fires before the debt limit once a refresh was pulled in.
    task automatic t_gap_urgent();
        t_reset();
        advance(IV);
        pulse_ack();
        pulse_ack();
        advance((DEBT + 1) * IV - MARG - 1);
        check(ref_urgent, 1'b0, "R7 urgent one edge before gap warning");
        advance(1);
        check(ref_urgent, 1'b1, "R7 urgent from gap below debt limit");
        check(ref_req, 1'b1, "R8 req with gap urgency");
        pulse_ack();
        check(ref_urgent, 1'b0, "R7 gap urgency cleared by ack");
        check(ref_req, 1'b1, "R3 req with credits still owed");
    endtask

    initial begin
        t_first_credit();
        t_saturate();
        t_pullin();
        t_coincident();
        t_gap_urgent();
        $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 200000);
        nvec++;
        nfail++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
        $finish;
    end

endmodule